// File: doc/BRIEF.md
# Lookup-Table Logic Cell with Registered Outputs

This block is one programmable logic cell for a reconfigurable fabric. Two 4-input lookup tables, called F and G, each return one stored bit. The four F inputs select the bit in F, and the four G inputs select the bit in G. A third, 3-input table called H takes the F result, the G result and one extra input. H can therefore build any function of five inputs, or it can act as a separate small function alongside F and G. Two flip-flops can capture any of the table results or the direct data input. Each flip-flop has a clock enable and a configurable set/reset value.

The cell is configured by shifting a 49-bit word in serially. Besides the table contents, the word carries the output routing, the flip-flop data sources, the set/reset values and a memory-mode flag. In memory mode the F and G tables become a 16-word by 2-bit writable store. A write takes one clock edge. Reads use the ordinary table lookup.

Top module: `logic_cell`

## Requirements
- R1: While `rst` is high at a rising edge, the whole configuration and both flip-flops clear. Afterwards `xq`=`yq`=0, and `x`=`y`=0 for every input.
- R2: Each edge with `cfg_en` high shifts `cfg_din` into the top of a 49-bit configuration word. Older bits move one place down, so the first of 49 bits ends at bit 0. Bit map:
  - F table: bits 15:0.
  - G table: bits 31:16.
  - H table: bits 39:32.
  - `xq` source: bits 41:40.
  - `yq` source: bits 43:42.
  - `x` select: bit 44.
  - `y` select: bit 45.
  - `xq` set/reset value: bit 46.
  - `yq` set/reset value: bit 47.
  - Memory mode: bit 48.
- R3: The F result is table bit number `f_in` (with `f_in[0]` as the LSB). The G result is table bit number `g_in`. Both are combinational.
- R4: The H result is H table bit number {`h_in`, G result, F result}, with the F result as the LSB.
- R5: `x` shows the F result when the `x` select is 0, and the H result when it is 1. `y` shows the G result when the `y` select is 0, and the H result when it is 1.
- R6: On a rising edge with `ce` high and `sr` low, each flip-flop loads its chosen source. Source code 0 selects the F result, 1 the G result, 2 the H result and 3 `din`.
- R7: With `ce` and `sr` both low, both flip-flops hold their value across an edge.
- R8: With `sr` high, each flip-flop loads its configured set/reset value on the next edge, whatever `ce` is.
- R9: In memory mode, an edge with `mem_we` high writes `din` into F bit `f_in` and `h_in` into G bit `f_in`. The new value is readable only after that edge.
- R10: Outside memory mode, `mem_we` has no effect on the tables.
- R11: With H table 0xCA and the `x` select set to 1, `x` is the G result when `h_in` is 1 and the F result when `h_in` is 0. This gives a 5-input function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit |
| mem_we | input | 1 | Table write enable (memory mode only) |
| f_in | input | 4 | F table inputs; write address in memory mode |
| g_in | input | 4 | G table inputs |
| h_in | input | 1 | Extra H input; G write data in memory mode |
| din | input | 1 | Direct flip-flop data; F write data in memory mode |
| sr | input | 1 | Set/reset request, overrides `ce` |
| ce | input | 1 | Flip-flop clock enable |
| x | output | 1 | Combinational output X |
| y | output | 1 | Combinational output Y |
| xq | output | 1 | Registered output X |
| yq | output | 1 | Registered output Y |

## Verification
The hardest case to reach from the ports is the memory-mode write and read-back. Table contents become visible only through the combinational lookup, and only after the writing edge. The stimulus holds `mem_we` and the address across a negative edge and checks that `x` still shows the old bit just before the rising edge. It then checks the new bit after the edge. Because H data feeds the G half of the same word, `g_in` is then pointed at the written address to confirm both halves. A second hard case is `sr` and `ce` high together with conflicting data. Here the configured set/reset values are chosen opposite to the selected source values, so the winner is visible.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_K    = 4;
  localparam int LUT_BITS = 1 << LUT_K;
  localparam int H_K      = 3;
  localparam int H_BITS   = 1 << H_K;
  localparam int SRC_W    = 2;

  localparam int F_LO    = 0;
  localparam int G_LO    = F_LO + LUT_BITS;
  localparam int H_LO    = G_LO + LUT_BITS;
  localparam int XSRC_LO = H_LO + H_BITS;
  localparam int YSRC_LO = XSRC_LO + SRC_W;
  localparam int XSEL_B  = YSRC_LO + SRC_W;
  localparam int YSEL_B  = XSEL_B + 1;
  localparam int XSRV_B  = YSEL_B + 1;
  localparam int YSRV_B  = XSRV_B + 1;
  localparam int MEM_B   = YSRV_B + 1;
  localparam int CFG_W   = MEM_B + 1;

  typedef enum logic [SRC_W-1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIN = 2'd3
  } ff_src_e;
endpackage

// File: rtl/lcell_cfg_store.sv
module lcell_cfg_store
  import lcell_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 shift_in,
  input  logic                 mem_we,
  input  logic [LUT_K-1:0]     mem_addr,
  input  logic                 mem_d_f,
  input  logic                 mem_d_g,
  output logic [CFG_W-1:0]     cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (shift_en) begin
      cfg <= {shift_in, cfg[CFG_W-1:1]};
    end else if (mem_we && cfg[MEM_B]) begin
      cfg[F_LO + int'(mem_addr)] <= mem_d_f;
      cfg[G_LO + int'(mem_addr)] <= mem_d_g;
    end
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> cfg[CFG_W-1] == $past(shift_in));
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> cfg[CFG_W-2:0] == $past(cfg[CFG_W-1:1]));
  // R9
  mem_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && cfg[MEM_B] && !shift_en)
      |=> cfg[F_LO + int'($past(mem_addr))] == $past(mem_d_f));
  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !cfg[MEM_B]) |=> $stable(cfg));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] table_bits,
  input  logic [K-1:0]     sel,
  output logic             y
);
  always_comb y = table_bits[sel];
endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic sr,
  input  logic srval,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (sr)  q <= srval;
    else if (ce)  q <= d;
  end

  // R8
  sr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    sr |=> q == $past(srval));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sr && !ce) |=> $stable(q));
  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (!sr && ce) |=> q == $past(d));
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic             mem_we,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic             h_in,
  input  logic             din,
  input  logic             sr,
  input  logic             ce,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq
);
  localparam int LANES = 2;

  logic [CFG_W-1:0] cfg;
  logic             f_val, g_val, h_val;
  logic [LANES-1:0] ff_d, ff_q, ff_srv;
  ff_src_e          ff_src [LANES];

  lcell_cfg_store u_store (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .shift_in (cfg_din),
    .mem_we   (mem_we),
    .mem_addr (f_in),
    .mem_d_f  (din),
    .mem_d_g  (h_in),
    .cfg      (cfg)
  );

  lcell_lut #(.K(LUT_K)) u_lut_f (
    .table_bits (cfg[F_LO +: LUT_BITS]),
    .sel        (f_in),
    .y          (f_val)
  );

  lcell_lut #(.K(LUT_K)) u_lut_g (
    .table_bits (cfg[G_LO +: LUT_BITS]),
    .sel        (g_in),
    .y          (g_val)
  );

  lcell_lut #(.K(H_K)) u_lut_h (
    .table_bits (cfg[H_LO +: H_BITS]),
    .sel        ({h_in, g_val, f_val}),
    .y          (h_val)
  );

  always_comb begin
    x = cfg[XSEL_B] ? h_val : f_val;
    y = cfg[YSEL_B] ? h_val : g_val;
  end

  always_comb begin
    ff_src[0] = ff_src_e'(cfg[XSRC_LO +: SRC_W]);
    ff_src[1] = ff_src_e'(cfg[YSRC_LO +: SRC_W]);
    ff_srv    = {cfg[YSRV_B], cfg[XSRV_B]};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (ff_src[i])
        SRC_F:   ff_d[i] = f_val;
        SRC_G:   ff_d[i] = g_val;
        SRC_H:   ff_d[i] = h_val;
        default: ff_d[i] = din;
      endcase
    end

    lcell_ff u_ff (
      .clk   (clk),
      .rst   (rst),
      .ce    (ce),
      .sr    (sr),
      .srval (ff_srv[i]),
      .d     (ff_d[i]),
      .q     (ff_q[i])
    );
  end

  assign xq = ff_q[0];
  assign yq = ff_q[1];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (xq == 1'b0 && yq == 1'b0 && x == 1'b0 && y == 1'b0));
endmodule

// File: tb/logic_cell_bench.sv
module logic_cell_bench;
  logic       clk = 1'b0;
  logic       rst, cfg_en, cfg_din, mem_we, h_in, din, sr, ce;
  logic [3:0] f_in, g_in;
  logic       x, y, xq, yq;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  logic_cell u_logic_cell (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .mem_we(mem_we),
    .f_in(f_in), .g_in(g_in), .h_in(h_in), .din(din), .sr(sr), .ce(ce),
    .x(x), .y(y), .xq(xq), .yq(yq)
  );

  // Sweep table. Fields: F 15:0, G 31:16, H 39:32, xsel 44, ysel 45.
  localparam logic [48:0] CFG_TAB [4] = '{
    49'h0_0000_6996_8000,   // AND4 / parity4, plain routing
    49'h0_10CA_BEEF_1234,   // H = 0xCA mux: 5-input function on x (R11)
    49'h0_2096_0001_FFFE,   // OR4 / NOR4, y from H (xor3)
    49'h0_30E8_3C5A_A5C3    // both outputs from H (majority)
  };

  function automatic logic [48:0] mk_cfg(input logic [15:0] f, input logic [15:0] g,
      input logic [7:0] h, input logic [1:0] xs, input logic [1:0] ys, input logic xsel,
      input logic ysel, input logic xsrv, input logic ysrv, input logic mem);
    return {mem, ysrv, xsrv, ysel, xsel, ys, xs, h, g, f};
  endfunction

  function automatic logic ref_h(input logic [48:0] c, input logic [3:0] fa,
      input logic [3:0] ga, input logic hx);
    logic fv, gv;
    fv = c[fa];
    gv = c[16 + int'(ga)];
    return c[32 + int'({hx, gv, fv})];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_cfg(input logic [48:0] v);
    for (int i = 0; i < 49; i++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = v[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    logic [48:0] c;
    logic        ex, ey, prev;
    rst = 1'b1; cfg_en = 0; cfg_din = 0; mem_we = 0; h_in = 0; din = 0;
    sr = 0; ce = 0; f_in = 0; g_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 xq", xq, 1'b0);
    check("R1 yq", yq, 1'b0);
    f_in = 4'hF; g_in = 4'hF; h_in = 1; #1;
    check("R1 x", x, 1'b0);
    check("R1 y", y, 1'b0);

    // R2 R3 R4 R5 R11: table sweep over all 512 input combinations
    foreach (CFG_TAB[k]) begin
      c = CFG_TAB[k];
      load_cfg(c);
      for (int v = 0; v < 512; v++) begin
        @(negedge clk);
        f_in = v[3:0]; g_in = v[7:4]; h_in = v[8];
        #1;
        ex = c[44] ? ref_h(c, f_in, g_in, h_in) : c[f_in];
        ey = c[45] ? ref_h(c, f_in, g_in, h_in) : c[16 + int'(g_in)];
        check("R3/R4/R5 x", x, ex);
        check("R3/R4/R5 y", y, ey);
        if (k == 1) check("R11 x", x, h_in ? c[16 + int'(g_in)] : c[f_in]);
      end
    end

    // R6: each flop source code (F'=1 always, G'=0 always, H'=h_in)
    for (int s = 0; s < 4; s++) begin
      load_cfg(mk_cfg(16'hFFFF, 16'h0000, 8'hF0, s[1:0], 2'd3, 0, 0, 0, 0, 0));
      @(negedge clk); ce = 1; h_in = 1; din = 0;
      @(negedge clk);
      check("R6 xq pat1", xq, (s == 0) ? 1'b1 : (s == 1) ? 1'b0 : (s == 2) ? 1'b1 : 1'b0);
      check("R6 yq din", yq, 1'b0);
      h_in = 0; din = 1;
      @(negedge clk);
      check("R6 xq pat2", xq, (s == 0) ? 1'b1 : (s == 1) ? 1'b0 : (s == 2) ? 1'b0 : 1'b1);
      check("R6 yq din", yq, 1'b1);
      ce = 0;
    end

    // R7: ce low holds (xq from din, now 1)
    prev = xq;
    din = 0; ce = 0;
    @(negedge clk);
    check("R7 xq hold", xq, prev);
    check("R7 yq hold", yq, 1'b1);

    // R8: sr beats ce; set values x=1, y=0, opposite to sources G'=0 and din=1
    load_cfg(mk_cfg(16'hFFFF, 16'h0000, 8'hF0, 2'd1, 2'd3, 0, 0, 1, 0, 0));
    @(negedge clk); ce = 1; din = 1; sr = 1;
    @(negedge clk);
    check("R8 xq set", xq, 1'b1);
    check("R8 yq reset", yq, 1'b0);
    sr = 0;
    @(negedge clk);
    check("R8 release xq", xq, 1'b0);
    check("R8 release yq", yq, 1'b1);
    ce = 0; sr = 1;
    @(negedge clk);
    check("R8 ce low xq", xq, 1'b1);
    check("R8 ce low yq", yq, 1'b0);
    sr = 0;

    // R1: mid-run reset clears flops and configuration
    rst = 1;
    @(negedge clk);
    rst = 0; f_in = 4'h0; g_in = 4'h0; #1;
    check("R1 mid xq", xq, 1'b0);
    check("R1 mid yq", yq, 1'b0);
    check("R1 mid x", x, 1'b0);

    // R9: memory mode write then read
    load_cfg(mk_cfg(16'h0000, 16'h0000, 8'h00, 0, 0, 0, 0, 0, 0, 1));
    @(negedge clk); mem_we = 1; f_in = 4'd5; g_in = 4'd5; din = 1; h_in = 0;
    #1;
    check("R9 before edge x", x, 1'b0);
    @(negedge clk); mem_we = 0; #1;
    check("R9 read F", x, 1'b1);
    check("R9 read G", y, 1'b0);
    mem_we = 1; din = 0; h_in = 1;
    @(negedge clk); mem_we = 0; #1;
    check("R9 rewrite F", x, 1'b0);
    check("R9 rewrite G", y, 1'b1);
    f_in = 4'd6; g_in = 4'd6; #1;
    check("R9 other addr F", x, 1'b0);
    check("R9 other addr G", y, 1'b0);

    // R10: write enable ignored outside memory mode
    load_cfg(mk_cfg(16'h0000, 16'h0000, 8'h00, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk); mem_we = 1; f_in = 4'd3; g_in = 4'd3; din = 1; h_in = 1;
    @(negedge clk); mem_we = 0; #1;
    check("R10 F unchanged", x, 1'b0);
    check("R10 G unchanged", y, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule